// File: doc/BRIEF.md
# Two-Rank Converter Input Latch

This block sits between a processor bus and a 12-bit converter core. It builds the converter's 12-bit input code from one or more bus writes, then hands the whole code over at once. There are two ranks. The first rank has three 4-bit slots, and each slot has its own active-low strobe. The second rank has one 12-bit holding stage, which has its own active-low transfer strobe. All four strobes act only while the shared active-low chip select is low. Every storage element is level-sensitive. It is transparent while enabled and holds once any of its controls rises.

Because each slot has its own strobe, several strobes can be pulled low in a single access. A narrow host writes the slots one at a time. A wide host can write all three slots, and even the transfer, in one access. The converter input changes only when the transfer stage is enabled, so it never shows a mixture of old and new nibbles.

Top module: `dac_word_latch`

## Requirements
- R1: While `rst` is high, both ranks are cleared to zero, so `dout` reads 0x000 and a later transfer with no nibble writes also yields 0x000.
- R2: With `cs_n` low and `strb_n[0]` low, first-rank bits 3..0 take `din[3..0]`; the other slots are unaffected.
- R3: With `cs_n` low and `strb_n[1]` low, first-rank bits 7..4 take `din[7..4]`.
- R4: With `cs_n` low and `strb_n[2]` low, first-rank bits 11..8 take `din[11..8]`.
- R5: A nibble write with `strb_n[3]` high leaves `dout` unchanged.
- R6: With `cs_n` low and `strb_n[3]` low, `dout` takes all 12 bits of the assembled first-rank word.
- R7: While `cs_n` is high, no stage is enabled, whatever the strobes are; neither `dout` nor the first rank changes.
- R8: While a stage is enabled it is transparent: a change on `din` during the enable reaches its output in the same access.
- R9: Once an enabling control returns high, the stage holds, and later changes on `din` have no effect.
- R10: Several nibble strobes may be low together (8- or 12-bit host), and each enabled slot loads its own field in that one access.
- R11: If a nibble strobe and `strb_n[3]` are low together, the nibble's data flows through both ranks to `dout` while both stay enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Active-high reset that clears both ranks, acting at once |
| cs_n | input | 1 | Active-low chip select that qualifies every strobe |
| strb_n | input | 4 | Active-low strobes: [0] low nibble, [1] middle, [2] high, [3] transfer |
| din | input | 12 | Data bus |
| dout | output | 12 | Code presented to the converter core |

## Verification
The first-rank load and the second-rank transfer can be active in the same access when a nibble strobe and the transfer strobe are low together. The bench provokes this with one nibble strobe plus the transfer strobe, and then with all four strobes low. It changes `din` while the strobes are held low, and judges `dout` against the word assembled from the earlier writes with the new nibble spliced in. After the strobes are released, the bench changes `din` again and expects `dout` to stay put.

// File: rtl/dac_latch_pkg.sv
package dac_latch_pkg;
  parameter int DEF_NIB_W   = 4;
  parameter int DEF_NIB_CNT = 3;

  function automatic int nib_lsb(input int idx, input int w);
    return idx * w;
  endfunction
endpackage

// File: rtl/dac_strobe_dec.sv
module dac_strobe_dec #(
  parameter int STB_CNT = 4
) (
  input  logic               cs_n,
  input  logic [STB_CNT-1:0] strb_n,
  output logic [STB_CNT-1:0] en
);
  for (genvar i = 0; i < STB_CNT; i++) begin : g_en
    assign en[i] = ~cs_n & ~strb_n[i];
  end
endmodule

// File: rtl/dac_level_latch.sv
module dac_level_latch #(
  parameter int W = 4
) (
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_latch begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/dac_word_latch.sv
module dac_word_latch
  import dac_latch_pkg::*;
#(
  parameter int NIB_W   = DEF_NIB_W,
  parameter int NIB_CNT = DEF_NIB_CNT,
  localparam int WORD_W = NIB_W * NIB_CNT,
  localparam int STB_CNT = NIB_CNT + 1
) (
  input  logic               rst,
  input  logic               cs_n,
  input  logic [STB_CNT-1:0] strb_n,
  input  logic [WORD_W-1:0]  din,
  output logic [WORD_W-1:0]  dout
);
  logic [STB_CNT-1:0] en;
  logic [WORD_W-1:0]  stage_q;

  dac_strobe_dec #(.STB_CNT(STB_CNT)) u_dec (
    .cs_n  (cs_n),
    .strb_n(strb_n),
    .en    (en)
  );

  for (genvar i = 0; i < NIB_CNT; i++) begin : g_nib
    localparam int LSB = nib_lsb(i, NIB_W);
    dac_level_latch #(.W(NIB_W)) u_nib (
      .rst(rst),
      .en (en[i]),
      .d  (din[LSB +: NIB_W]),
      .q  (stage_q[LSB +: NIB_W])
    );
  end

  dac_level_latch #(.W(WORD_W)) u_xfer (
    .rst(rst),
    .en (en[NIB_CNT]),
    .d  (stage_q),
    .q  (dout)
  );
endmodule

// File: rtl/dac_word_latch_chk.sv
module dac_word_latch_chk #(
  parameter int NIB_W   = 4,
  parameter int NIB_CNT = 3,
  localparam int WORD_W = NIB_W * NIB_CNT,
  localparam int STB_CNT = NIB_CNT + 1
) (
  input logic               rst,
  input logic               cs_n,
  input logic [STB_CNT-1:0] strb_n,
  input logic [WORD_W-1:0]  din,
  input logic [WORD_W-1:0]  stage_q,
  input logic [WORD_W-1:0]  dout
);
  always_comb begin
    if (rst) begin
      // R1
      rst_clear_chk: assert (dout == '0 && stage_q == '0);
    end
  end

  always_comb begin
    if (!rst && !cs_n && !strb_n[NIB_CNT]) begin
      // R6
      xfer_copy_chk: assert (dout == stage_q);
    end
  end

  for (genvar i = 0; i < NIB_CNT; i++) begin : g_nchk
    always_comb begin
      if (!rst && !cs_n && !strb_n[i]) begin
        // R8
        nib_follow_chk: assert (stage_q[i*NIB_W +: NIB_W] == din[i*NIB_W +: NIB_W]);
      end
    end
    always_comb begin
      if (!rst && !cs_n && !strb_n[i] && !strb_n[NIB_CNT]) begin
        // R11
        flow_through_chk: assert (dout[i*NIB_W +: NIB_W] == din[i*NIB_W +: NIB_W]);
      end
    end
  end
endmodule

bind dac_word_latch dac_word_latch_chk #(.NIB_W(NIB_W), .NIB_CNT(NIB_CNT)) u_chk (
  .rst    (rst),
  .cs_n   (cs_n),
  .strb_n (strb_n),
  .din    (din),
  .stage_q(stage_q),
  .dout   (dout)
);

// File: tb/dac_word_latch_bench.sv
module dac_word_latch_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic [3:0]  strb_n = 4'hF;
  logic [11:0] din = '0;
  logic [11:0] dout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [11:0] exp_q[$];
  string       tag_q[$];
  logic [11:0] exp_v;
  string       tag_v;

  always #4 clk = ~clk;

  dac_word_latch u_dac_word_latch (
    .rst   (rst),
    .cs_n  (cs_n),
    .strb_n(strb_n),
    .din   (din),
    .dout  (dout)
  );

  // Monitor: compares each queued expectation at the falling edge after it was driven
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_v = exp_q.pop_front();
      tag_v = tag_q.pop_front();
      checks++;
      if (dout !== exp_v) begin
        fails++;
        $display("FAIL %s: dout=%h expected %h", tag_v, dout, exp_v);
      end
    end
  end

  task automatic apply(input logic r, input logic c, input logic [3:0] s,
                       input logic [11:0] d, input logic [11:0] e, input string tag);
    @(posedge clk);
    rst = r; cs_n = c; strb_n = s; din = d;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    apply(1, 1, 4'hF, 12'hFFF, 12'h000, "R1 reset");
    apply(0, 1, 4'hF, 12'hFFF, 12'h000, "R1 after reset");
    apply(0, 0, 4'b0111, 12'hFFF, 12'h000, "R1 cleared first rank");
    apply(0, 1, 4'hF, 12'hFFF, 12'h000, "R9 release");
    // low nibble
    apply(0, 0, 4'b1110, 12'hABC, 12'h000, "R5 low write");
    apply(0, 1, 4'hF, 12'hABC, 12'h000, "R5 release");
    apply(0, 1, 4'hF, 12'h123, 12'h000, "R9 din change");
    apply(0, 0, 4'b0111, 12'h123, 12'h00C, "R2 transfer");
    apply(0, 1, 4'hF, 12'h123, 12'h00C, "R9 release");
    // middle nibble
    apply(0, 0, 4'b1101, 12'h456, 12'h00C, "R5 mid write");
    apply(0, 1, 4'hF, 12'h456, 12'h00C, "R5 release");
    apply(0, 0, 4'b0111, 12'h000, 12'h05C, "R3 transfer");
    apply(0, 1, 4'hF, 12'h000, 12'h05C, "R9 release");
    // high nibble
    apply(0, 0, 4'b1011, 12'h789, 12'h05C, "R5 high write");
    apply(0, 1, 4'hF, 12'h789, 12'h05C, "R5 release");
    apply(0, 0, 4'b0111, 12'h000, 12'h75C, "R4 R6 transfer");
    apply(0, 1, 4'hF, 12'h000, 12'h75C, "R9 release");
    // chip select high masks every strobe
    apply(0, 1, 4'b0000, 12'h000, 12'h75C, "R7 cs high");
    apply(0, 1, 4'hF, 12'h000, 12'h75C, "R7 release");
    apply(0, 0, 4'b0111, 12'hFFF, 12'h75C, "R7 first rank intact");
    apply(0, 1, 4'hF, 12'hFFF, 12'h75C, "R9 release");
    // 8-bit host: two nibbles at once
    apply(0, 0, 4'b1100, 12'h9A3, 12'h75C, "R10 byte write");
    apply(0, 1, 4'hF, 12'h9A3, 12'h75C, "R10 release");
    apply(0, 0, 4'b0111, 12'h000, 12'h7A3, "R10 byte transfer");
    apply(0, 1, 4'hF, 12'h000, 12'h7A3, "R9 release");
    // 12-bit host: all nibbles at once
    apply(0, 0, 4'b1000, 12'hE1F, 12'h7A3, "R10 word write");
    apply(0, 1, 4'hF, 12'hE1F, 12'h7A3, "R10 release");
    apply(0, 0, 4'b0111, 12'h000, 12'hE1F, "R10 word transfer");
    apply(0, 1, 4'hF, 12'h000, 12'hE1F, "R9 release");
    // nibble and transfer together
    apply(0, 0, 4'b0110, 12'h004, 12'hE14, "R11 flow through");
    apply(0, 0, 4'b0110, 12'h00B, 12'hE1B, "R8 transparent follow");
    apply(0, 1, 4'hF, 12'h00B, 12'hE1B, "R9 release");
    apply(0, 1, 4'hF, 12'h000, 12'hE1B, "R9 hold after flow");
    apply(0, 0, 4'b0000, 12'h321, 12'h321, "R11 all strobes");
    apply(0, 1, 4'hF, 12'h321, 12'h321, "R9 release");
    apply(0, 1, 4'hF, 12'hFFF, 12'h321, "R9 hold after all");
    // reset again mid-run
    apply(1, 1, 4'hF, 12'hFFF, 12'h000, "R1 reset mid run");
    apply(0, 0, 4'b0111, 12'hFFF, 12'h000, "R1 cleared after reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      summary();
      $finish;
    end
  end
endmodule